// File: doc/BRIEF.md
# Two-Player Paddle Game State Engine

This block holds the whole state of a two-player paddle-and-ball game and advances it once per video frame. A ball travels diagonally across a 640x480 field, bounces off the top and bottom walls and off two paddles. Each paddle is steered by a pair of key-down levels. When the ball gets past a paddle, the other player scores and the ball is served again from the middle of the field.

Every state change happens in a single clock cycle, triggered by the rising edge of the vertical sync level. A separate timing generator supplies the current pixel coordinates. From the registered game state the block returns a pixel class for that coordinate (background, ball or paddle), and it also presents both scores and a game-over flag. When either score reaches the winning count, the game freezes until reset.

Top module: `pong_engine`

## Requirements
- R1: After reset both scores are 0, game_over_o is 0, and both paddles have top row 220. The ball's top-left corner is at (315,235) and it moves right (+x) and down (+y).
- R2: State changes only in the clock cycle after vsync_i is first seen high following a low sample. Holding vsync_i high, or changing keys while vsync_i stays low, leaves the state unchanged.
- R3: On each frame update a paddle moves 4 rows up (toward row 0) while only its up key is held, and 4 rows down while only its down key is held. With both keys held or neither held, it holds its position.
- R4: A paddle's top row is clamped to the range 0 to 440, so that the whole 40-row paddle stays inside the 480-row field.
- R5: On each frame update the ball moves 3 pixels on each axis in its current direction.
- R6: If the stepped ball would leave the field at the top (y<0) or at the bottom (y>470), it is placed against that wall and its vertical direction reverses.
- R7: The ball may move left and overlap the left paddle (x 20 to 29, top row as before the update). In that case it is placed at x=30 and turns right. The ball may instead move right and overlap the right paddle (x 610 to 619). In that case it is placed at x=600 and turns left.
- R8: If the stepped ball, not hitting a paddle, has x<0, the right score increments. If it has x>630, the left score increments. In both cases the ball returns to (315,235) and heads toward the player who conceded. Its vertical direction is kept.
- R9: When either score equals 5, game_over_o is 1, and the ball, both paddles and the scores no longer change until reset.
- R10: pix_o is 1 when the coordinate lies inside the 10x10 ball. Otherwise it is 2 inside a 10-column by 40-row paddle, and 0 everywhere else. The ball has priority over a paddle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsync_i | input | 1 | Vertical sync level; its rising edge starts a frame update |
| l_up_i | input | 1 | Left paddle up key held |
| l_dn_i | input | 1 | Left paddle down key held |
| r_up_i | input | 1 | Right paddle up key held |
| r_dn_i | input | 1 | Right paddle down key held |
| px_x_i | input | 10 | Current pixel column |
| px_y_i | input | 9 | Current pixel row |
| pix_o | output | 2 | Pixel class: 0 background, 1 ball, 2 paddle |
| score_l_o | output | 3 | Left player score |
| score_r_o | output | 3 | Right player score |
| game_over_o | output | 1 | A score has reached the winning count |

## Verification
The assertions check a set of invariants on every cycle. Nothing moves outside a frame tick. Paddle steps are bounded by 4 rows and paddles stay within range. The ball stays inside the vertical field. Scores advance by at most one per frame. Once game over is set, nothing changes. Only the bench's scenarios can show the exact positions after a bounce, a paddle reflection or a goal, the direction of the serve, and the pixel priority. The bench compares probes of pixel coordinates against an arithmetic model of the game, running over long key sequences that play a full game to its end.

// File: rtl/pong_pkg.sv
package pong_pkg;
  typedef enum logic [1:0] {
    PIX_BG   = 2'd0,
    PIX_BALL = 2'd1,
    PIX_PAD  = 2'd2
  } pix_e;
endpackage

// File: rtl/pong_paddle.sv
module pong_paddle #(
  parameter int SCR_H    = 480,
  parameter int PAD_H    = 40,
  parameter int PAD_STEP = 4,
  parameter int YW       = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          freeze_i,
  input  logic          up_i,
  input  logic          dn_i,
  output logic [YW-1:0] y_o
);
  localparam logic [YW-1:0] YMAX = YW'(SCR_H - PAD_H);
  localparam logic [YW-1:0] YCEN = YW'((SCR_H - PAD_H) / 2);
  localparam logic [YW-1:0] STEP = YW'(PAD_STEP);

  logic [YW-1:0] y_q, y_d;

  always_comb begin
    y_d = y_q;
    if (up_i && !dn_i)      y_d = (y_q < STEP) ? '0 : y_q - STEP;
    else if (dn_i && !up_i) y_d = (y_q > YMAX - STEP) ? YMAX : y_q + STEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 y_q <= YCEN;
    else if (tick_i && !freeze_i) y_q <= y_d;
  end

  assign y_o = y_q;

  AST_PAD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_q <= YMAX); // R4
  AST_PAD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(y_q)); // R2
  AST_PAD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(y_q)); // R9
  AST_PAD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> ((YW+1)'(y_q) <= (YW+1)'($past(y_q)) + (YW+1)'(PAD_STEP)) &&
               ((YW+1)'(y_q) + (YW+1)'(PAD_STEP) >= (YW+1)'($past(y_q)))); // R3
endmodule

// File: rtl/pong_ball.sv
module pong_ball #(
  parameter int SCR_W     = 640,
  parameter int SCR_H     = 480,
  parameter int BALL_SZ   = 10,
  parameter int BALL_STEP = 3,
  parameter int PAD_H     = 40,
  parameter int PAD_W     = 10,
  parameter int PAD_X     = 20,
  parameter int WIN_SCORE = 5,
  parameter int XW        = 10,
  parameter int YW        = 9,
  parameter int SW        = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [YW-1:0] pad_l_i,
  input  logic [YW-1:0] pad_r_i,
  output logic [XW-1:0] bx_o,
  output logic [YW-1:0] by_o,
  output logic [SW-1:0] score_l_o,
  output logic [SW-1:0] score_r_o,
  output logic          over_o
);
  localparam int XMAX = SCR_W - BALL_SZ;
  localparam int YMAX = SCR_H - BALL_SZ;
  localparam int XC   = XMAX / 2;
  localparam int YC   = YMAX / 2;
  localparam int RX   = SCR_W - PAD_X - PAD_W;
  localparam logic [SW-1:0] WIN_V = SW'(WIN_SCORE);

  logic [XW-1:0] bx_q, bx_d;
  logic [YW-1:0] by_q, by_d;
  logic          dx_q, dx_d, dy_q, dy_d; // 1: +x (right) / +y (down)
  logic [SW-1:0] sl_q, sl_d, sr_q, sr_d;
  logic          hit_l, hit_r;
  int            nx, ny;

  assign over_o = (sl_q == WIN_V) || (sr_q == WIN_V);

  always_comb begin
    nx   = int'(bx_q) + (dx_q ? BALL_STEP : -BALL_STEP);
    ny   = int'(by_q) + (dy_q ? BALL_STEP : -BALL_STEP);
    dx_d = dx_q;
    dy_d = dy_q;
    sl_d = sl_q;
    sr_d = sr_q;
    if (ny < 0) begin
      ny = 0; dy_d = 1'b1;
    end else if (ny > YMAX) begin
      ny = YMAX; dy_d = 1'b0;
    end
    hit_l = !dx_q && (nx < PAD_X + PAD_W) && (nx + BALL_SZ > PAD_X) &&
            (ny + BALL_SZ > int'(pad_l_i)) && (ny < int'(pad_l_i) + PAD_H);
    hit_r = dx_q && (nx + BALL_SZ > RX) && (nx < RX + PAD_W) &&
            (ny + BALL_SZ > int'(pad_r_i)) && (ny < int'(pad_r_i) + PAD_H);
    if (hit_l) begin
      nx = PAD_X + PAD_W; dx_d = 1'b1;
    end else if (hit_r) begin
      nx = RX - BALL_SZ; dx_d = 1'b0;
    end else if (nx < 0) begin
      sr_d = sr_q + 1'b1; nx = XC; ny = YC; dx_d = 1'b0;
    end else if (nx > XMAX) begin
      sl_d = sl_q + 1'b1; nx = XC; ny = YC; dx_d = 1'b1;
    end
    bx_d = XW'(nx);
    by_d = YW'(ny);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bx_q <= XW'(XC);
      by_q <= YW'(YC);
      dx_q <= 1'b1;
      dy_q <= 1'b1;
      sl_q <= '0;
      sr_q <= '0;
    end else if (tick_i && !over_o) begin
      bx_q <= bx_d;
      by_q <= by_d;
      dx_q <= dx_d;
      dy_q <= dy_d;
      sl_q <= sl_d;
      sr_q <= sr_d;
    end
  end

  assign bx_o      = bx_q;
  assign by_o      = by_q;
  assign score_l_o = sl_q;
  assign score_r_o = sr_q;

  AST_BALL_IN_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(by_q) <= YMAX && int'(bx_q) <= XMAX); // R6
  AST_BALL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(bx_q) && $stable(by_q)); // R2
  AST_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_o |=> $stable(bx_q) && $stable(by_q) && $stable(sl_q) && $stable(sr_q)); // R9
  AST_SCORE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (sl_q == $past(sl_q) || sl_q == SW'($past(sl_q) + 1'b1)) &&
             (sr_q == $past(sr_q) || sr_q == SW'($past(sr_q) + 1'b1))); // R8
  AST_ONE_GOAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> !((sl_q != $past(sl_q)) && (sr_q != $past(sr_q)))); // R8
endmodule

// File: rtl/pong_render.sv
module pong_render #(
  parameter int SCR_W   = 640,
  parameter int BALL_SZ = 10,
  parameter int PAD_H   = 40,
  parameter int PAD_W   = 10,
  parameter int PAD_X   = 20,
  parameter int XW      = 10,
  parameter int YW      = 9
) (
  input  logic [XW-1:0]   px_x_i,
  input  logic [YW-1:0]   px_y_i,
  input  logic [XW-1:0]   bx_i,
  input  logic [YW-1:0]   by_i,
  input  logic [YW-1:0]   pad_l_i,
  input  logic [YW-1:0]   pad_r_i,
  output pong_pkg::pix_e  pix_o
);
  localparam int RX = SCR_W - PAD_X - PAD_W;

  logic in_ball, in_l, in_r;
  int   x, y;

  always_comb begin
    x       = int'(px_x_i);
    y       = int'(px_y_i);
    in_ball = (x >= int'(bx_i)) && (x < int'(bx_i) + BALL_SZ) &&
              (y >= int'(by_i)) && (y < int'(by_i) + BALL_SZ);
    in_l    = (x >= PAD_X) && (x < PAD_X + PAD_W) &&
              (y >= int'(pad_l_i)) && (y < int'(pad_l_i) + PAD_H);
    in_r    = (x >= RX) && (x < RX + PAD_W) &&
              (y >= int'(pad_r_i)) && (y < int'(pad_r_i) + PAD_H);
    if (in_ball)            pix_o = pong_pkg::PIX_BALL;
    else if (in_l || in_r)  pix_o = pong_pkg::PIX_PAD;
    else                    pix_o = pong_pkg::PIX_BG;
  end
endmodule

// File: rtl/pong_engine.sv
module pong_engine #(
  parameter int SCR_W     = 640,
  parameter int SCR_H     = 480,
  parameter int BALL_SZ   = 10,
  parameter int BALL_STEP = 3,
  parameter int PAD_H     = 40,
  parameter int PAD_W     = 10,
  parameter int PAD_X     = 20,
  parameter int PAD_STEP  = 4,
  parameter int WIN_SCORE = 5,
  localparam int XW = $clog2(SCR_W),
  localparam int YW = $clog2(SCR_H),
  localparam int SW = $clog2(WIN_SCORE + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vsync_i,
  input  logic          l_up_i,
  input  logic          l_dn_i,
  input  logic          r_up_i,
  input  logic          r_dn_i,
  input  logic [XW-1:0] px_x_i,
  input  logic [YW-1:0] px_y_i,
  output logic [1:0]    pix_o,
  output logic [SW-1:0] score_l_o,
  output logic [SW-1:0] score_r_o,
  output logic          game_over_o
);
  logic          vs_q, tick, over;
  logic [1:0]    up, dn;
  logic [YW-1:0] pad_y [2];
  logic [XW-1:0] bx;
  logic [YW-1:0] by;
  pong_pkg::pix_e pix;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vs_q <= 1'b0;
    else         vs_q <= vsync_i;
  end
  assign tick = vsync_i && !vs_q;

  assign up = {r_up_i, l_up_i};
  assign dn = {r_dn_i, l_dn_i};

  for (genvar g = 0; g < 2; g++) begin : g_pad
    pong_paddle #(
      .SCR_H(SCR_H), .PAD_H(PAD_H), .PAD_STEP(PAD_STEP), .YW(YW)
    ) u_pad (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .freeze_i(over),
      .up_i(up[g]), .dn_i(dn[g]), .y_o(pad_y[g])
    );
  end

  pong_ball #(
    .SCR_W(SCR_W), .SCR_H(SCR_H), .BALL_SZ(BALL_SZ), .BALL_STEP(BALL_STEP),
    .PAD_H(PAD_H), .PAD_W(PAD_W), .PAD_X(PAD_X), .WIN_SCORE(WIN_SCORE),
    .XW(XW), .YW(YW), .SW(SW)
  ) u_ball (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .pad_l_i(pad_y[0]), .pad_r_i(pad_y[1]),
    .bx_o(bx), .by_o(by), .score_l_o(score_l_o), .score_r_o(score_r_o),
    .over_o(over)
  );

  pong_render #(
    .SCR_W(SCR_W), .BALL_SZ(BALL_SZ), .PAD_H(PAD_H), .PAD_W(PAD_W),
    .PAD_X(PAD_X), .XW(XW), .YW(YW)
  ) u_render (
    .px_x_i(px_x_i), .px_y_i(px_y_i), .bx_i(bx), .by_i(by),
    .pad_l_i(pad_y[0]), .pad_r_i(pad_y[1]), .pix_o(pix)
  );

  assign pix_o       = pix;
  assign game_over_o = over;

  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick); // R2
endmodule

// File: tb/test_pong_engine.sv
module test_pong_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vsync = 1'b0;
  logic lu = 0, ld = 0, ru = 0, rd = 0;
  logic [9:0] px_x = '0;
  logic [8:0] px_y = '0;
  logic [1:0] pix;
  logic [2:0] sl, sr;
  logic       over;

  int n_chk = 0, n_fail = 0;
  int m_bx, m_by, m_dx, m_dy, m_pl, m_pr, m_sl, m_sr;
  string ev;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  pong_engine i_pong_engine (
    .clk_i(clk), .rst_ni(rst_n), .vsync_i(vsync),
    .l_up_i(lu), .l_dn_i(ld), .r_up_i(ru), .r_dn_i(rd),
    .px_x_i(px_x), .px_y_i(px_y), .pix_o(pix),
    .score_l_o(sl), .score_r_o(sr), .game_over_o(over)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_pix(input int x, input int y);
    if (x >= m_bx && x < m_bx + 10 && y >= m_by && y < m_by + 10) return 1;
    if (y >= m_pl && y < m_pl + 40 && x >= 20 && x < 30) return 2;
    if (y >= m_pr && y < m_pr + 40 && x >= 610 && x < 620) return 2;
    return 0;
  endfunction

  task automatic probe(input int x, input int y, input string tag);
    if (x < 0 || x >= 640 || y < 0 || y >= 480) return;
    @(negedge clk);
    px_x = 10'(x);
    px_y = 9'(y);
    #1;
    chk(int'(pix) == exp_pix(x, y), $sformatf("%s pix(%0d,%0d)", tag, x, y),
        int'(pix), exp_pix(x, y));
  endtask

  task automatic check_all(input string tag);
    probe(m_bx, m_by, tag);           probe(m_bx + 9, m_by + 9, tag);
    probe(m_bx - 1, m_by, tag);       probe(m_bx + 10, m_by + 9, tag);
    probe(m_bx, m_by - 1, tag);       probe(m_bx + 9, m_by + 10, tag);
    probe(25, m_pl, tag);  probe(25, m_pl + 39, tag);
    probe(25, m_pl - 1, tag); probe(25, m_pl + 40, tag);
    probe(615, m_pr, tag); probe(615, m_pr + 39, tag);
    probe(615, m_pr - 1, tag); probe(615, m_pr + 40, tag);
    chk(int'(sl) == m_sl, {tag, " score_l"}, int'(sl), m_sl);
    chk(int'(sr) == m_sr, {tag, " score_r"}, int'(sr), m_sr);
    chk(int'(over) == int'(m_sl == 5 || m_sr == 5), {tag, " game_over"},
        int'(over), int'(m_sl == 5 || m_sr == 5));
  endtask

  task automatic model_reset();
    m_bx = 315; m_by = 235; m_dx = 1; m_dy = 1;
    m_pl = 220; m_pr = 220; m_sl = 0; m_sr = 0;
  endtask

  function automatic int pad_next(input int y, input logic u, input logic d);
    if (u && !d) return (y < 4) ? 0 : y - 4;
    if (d && !u) return (y > 436) ? 440 : y + 4;
    return y;
  endfunction

  // Arithmetic game model; sets ev to the dominant event of the frame
  task automatic model_step();
    int nx, ny;
    bit hl, hr;
    ev = "R5 move";
    if (m_sl == 5 || m_sr == 5) begin
      ev = "R9 frozen";
      return;
    end
    nx = m_bx + (m_dx ? 3 : -3);
    ny = m_by + (m_dy ? 3 : -3);
    if (ny < 0) begin ny = 0; m_dy = 1; ev = "R6 top"; end
    else if (ny > 470) begin ny = 470; m_dy = 0; ev = "R6 bottom"; end
    hl = !m_dx && nx < 30 && nx + 10 > 20 && ny + 10 > m_pl && ny < m_pl + 40;
    hr = m_dx && nx + 10 > 610 && nx < 620 && ny + 10 > m_pr && ny < m_pr + 40;
    if (hl) begin nx = 30; m_dx = 1; ev = "R7 left hit"; end
    else if (hr) begin nx = 600; m_dx = 0; ev = "R7 right hit"; end
    else if (nx < 0) begin m_sr++; nx = 315; ny = 235; m_dx = 0; ev = "R8 right goal"; end
    else if (nx > 630) begin m_sl++; nx = 315; ny = 235; m_dx = 1; ev = "R8 left goal"; end
    m_bx = nx; m_by = ny;
    m_pl = pad_next(m_pl, lu, ld);
    m_pr = pad_next(m_pr, ru, rd);
  endtask

  task automatic frame(input string tag);
    @(negedge clk) vsync = 1'b1;
    @(negedge clk) vsync = 1'b0;
    @(negedge clk);
    model_step();
    if (ev == "R5 move") check_all(tag);
    else check_all({tag, "/", ev});
  endtask

  task automatic set_keys(input logic a, input logic b, input logic c, input logic d);
    @(negedge clk);
    lu = a; ld = b; ru = c; rd = d;
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    lu = 0; ld = 0; ru = 0; rd = 0; vsync = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    int frames;
    do_reset();
    check_all("R1 reset");

    // R2: keys change without vsync edge, then vsync held high for many cycles
    set_keys(1, 0, 0, 1);
    repeat (6) @(negedge clk);
    check_all("R2 no edge");
    @(negedge clk) vsync = 1'b1;
    repeat (10) @(negedge clk);
    vsync = 1'b0;
    @(negedge clk);
    model_step();
    check_all("R2 single update");

    // R3: each key combination
    set_keys(1, 0, 0, 1); frame("R3 up/down");
    set_keys(0, 1, 1, 0); frame("R3 down/up");
    set_keys(1, 1, 1, 1); frame("R3 both held");
    set_keys(0, 0, 0, 0); frame("R3 none held");

    // R4: drive paddles to both clamps
    set_keys(1, 0, 0, 1);
    for (int i = 0; i < 60; i++) frame("R4 clamp");
    chk(m_pl == 0 && m_pr == 440, "R4 model at limits", m_pl, 0);
    set_keys(0, 1, 1, 0);
    for (int i = 0; i < 120; i++) frame("R4 clamp");

    // Sweep: left keys pseudo-random, right paddle parked at top
    frames = 0;
    while (!(m_sl == 5 || m_sr == 5) && frames < 5000) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      set_keys(lfsr[0], lfsr[1], 1'b1, 1'b0);
      frame("R5 sweep");
      frames++;
    end
    chk(m_sl == 5 || m_sr == 5, "R9 game reached end", m_sl + m_sr, 5);

    // R9: frozen state with keys active
    for (int i = 0; i < 20; i++) begin
      set_keys(i[0], !i[0], !i[0], i[0]);
      frame("R9 freeze");
    end
    chk(over == 1'b1, "R9 over held", int'(over), 1);

    // R1 again: reset releases the freeze
    do_reset();
    check_all("R1 re-reset");
    frame("R5 after reset");

    // R10: background and priority points
    probe(0, 0, "R10 corner");
    probe(639, 479, "R10 corner");
    probe(320, 100, "R10 background");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule